// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Cycle Controller

This block turns a one-clock internal request (address, read flag, write data) into a complete external bus cycle on a narrow, shared-pin bus. It generates a free-running E clock at one quarter of the system clock. It also drives the upper address byte and a read/write line on dedicated outputs. A single 8-bit pin group carries the low address byte while E is low and the data byte while E is high. An address strobe marks the point where an external transparent latch should close on the low address byte.

For a static RAM on the bus, the block produces an active-low write enable and an active-low chip select. The write enable is the NAND of E and the inverted read/write line. The chip select is decoded from the top address bits against a configurable 8 KB block number.

Every transfer takes exactly one E period. Read data is sampled on the edge where E falls and is returned together with a one-clock done pulse. A request that arrives during a transfer is held in a single waiting slot and starts in the following E period. While no transfer is running, E keeps toggling and every strobe and enable stays inactive.

Top module: `xbus_ctrl`

## Requirements
- R1: E is low for 2 system clocks and then high for 2 system clocks, repeating with a period of 4 clocks without interruption, including while idle. After reset is released it starts in its low half.
- R2: The address strobe is high only in the first clock of the E-low half of a period that carries a transfer. It lasts exactly one clock and is never high while idle.
- R3: The upper address byte (request address bits 15..8) and the read/write line (1 = read, 0 = write) are valid from the first clock of the transfer and do not change while E is high. While idle the read/write line reads 1.
- R4: During the E-low half of a transfer, the shared pins carry request address bits 7..0 with the pin output enable high. During the E-high half of a write, they carry the write data with the output enable high.
- R5: On a read, the pin output enable is low for the whole E-high half. The value on the pin inputs at the clock edge where E falls is presented on the read-data output, which is valid in the clock that follows.
- R6: The active-low write enable equals NOT(E AND NOT read/write). It is therefore low for exactly the two E-high clocks of a write and high otherwise.
- R7: The active-low chip select is low for all four clocks of a transfer whose address bits 15..13 equal the configured block number (default 3'b010, i.e. 0x4000-0x5FFF). It is high for other addresses and while idle.
- R8: Each transfer, read or write, ends with done high for exactly one clock, which is the first clock after E falls. A write leaves the read-data output unchanged.
- R9: A request given while idle starts its transfer at the next E period boundary, so the address strobe appears 1 to 4 clocks after the request clock.
- R10: A request given during a transfer waits. Its transfer starts in the E period directly after, so its address strobe coincides with the done pulse of the previous transfer.
- R11: There is one waiting slot. A request given while the slot is occupied, and not being emptied on that edge, is dropped and produces no transfer.
- R12: During reset, E, the address strobe, done and the pin output enable are low, the write enable and chip select are high, and the read-data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-clock request pulse |
| req_addr_i | input | 16 | Request address |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-clock transfer-complete pulse |
| rdata_o | output | 8 | Last read data |
| e_o | output | 1 | Bus E clock |
| as_o | output | 1 | Address strobe for the external low-address latch |
| rw_o | output | 1 | Read/write line, 1 = read |
| ah_o | output | 8 | Upper address byte |
| pad_o | output | 8 | Shared pin output value (low address or data) |
| pad_oe_o | output | 1 | Shared pin output enable |
| pad_i | input | 8 | Shared pin input value |
| we_n_o | output | 1 | Active-low write enable for the RAM |
| cs_n_o | output | 1 | Active-low chip select for the RAM |

## Verification
A wrong phase count shows at once as an E pattern other than two low and two high clocks. It also shows as a strobe or write enable falling in the wrong half, which is visible within one 4-clock period. A corrupted cycle register shows within the same period as a wrong upper byte, wrong low byte on the pins, or a wrong select. A lost or duplicated request in the waiting slot shows only at the next period boundary, as a missing or extra strobe, and a faulty read capture shows in the done clock as a wrong read value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int unsigned XB_AW = 16;
  localparam int unsigned XB_DW = 8;

  typedef struct packed {
    logic [XB_AW-1:0] addr;
    logic             rd;
    logic [XB_DW-1:0] wdata;
  } xbus_req_t;
endpackage

// File: rtl/xbus_phase_gen.sv
module xbus_phase_gen #(
  parameter int unsigned HALF_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic e_o,
  output logic first_o,
  output logic last_o
);
  localparam int unsigned PERIOD = 2 * HALF_CLKS;
  localparam int unsigned PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0] ph_q, ph_d;

  assign last_o  = (ph_q == PH_W'(PERIOD - 1));
  assign first_o = (ph_q == '0);
  assign e_o     = (ph_q >= PH_W'(HALF_CLKS));

  always_comb begin
    if (last_o) ph_d = '0;
    else        ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) ph_q <= '0;
    else          ph_q <= ph_d;
  end
endmodule

// File: rtl/xbus_req_slot.sv
module xbus_req_slot
  import xbus_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  logic      req_i,
  input  xbus_req_t req_data_i,
  input  logic      boundary_i,
  output logic      launch_o,
  output xbus_req_t launch_data_o
);
  logic      pend_q, pend_d;
  xbus_req_t pdat_q, pdat_d;
  logic      pdat_en;

  assign launch_o      = boundary_i && (pend_q || req_i);
  assign launch_data_o = pend_q ? pdat_q : req_data_i;

  always_comb begin
    pend_d  = pend_q;
    pdat_d  = pdat_q;
    pdat_en = 1'b0;
    if (launch_o) begin
      // slot drains; a fresh request refills it only if the slot was the source
      pend_d = pend_q && req_i;
      if (pend_q && req_i) begin
        pdat_d  = req_data_i;
        pdat_en = 1'b1;
      end
    end else if (req_i && !pend_q) begin
      pend_d  = 1'b1;
      pdat_d  = req_data_i;
      pdat_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pend_q <= 1'b0;
    else          pend_q <= pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     pdat_q <= '0;
    else if (pdat_en) pdat_q <= pdat_d;
  end
endmodule

// File: rtl/xbus_cs_dec.sv
module xbus_cs_dec #(
  parameter int unsigned             DEC_W    = 3,
  parameter logic [DEC_W-1:0]        CS_BLOCK = DEC_W'(2)
) (
  input  logic [DEC_W-1:0] top_bits_i,
  input  logic             active_i,
  output logic             cs_n_o
);
  logic hit;
  assign hit    = (top_bits_i == CS_BLOCK);
  assign cs_n_o = ~(active_i & hit);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned      HALF_CLKS = 2,
  parameter int unsigned      DEC_W     = 3,
  parameter logic [DEC_W-1:0] CS_BLOCK  = DEC_W'(2)
) (
  input  logic                   clk_i,
  input  logic                   rst_n_i,
  input  logic                   req_i,
  input  logic [XB_AW-1:0]       req_addr_i,
  input  logic                   req_rd_i,
  input  logic [XB_DW-1:0]       req_wdata_i,
  output logic                   done_o,
  output logic [XB_DW-1:0]       rdata_o,
  output logic                   e_o,
  output logic                   as_o,
  output logic                   rw_o,
  output logic [XB_AW-XB_DW-1:0] ah_o,
  output logic [XB_DW-1:0]       pad_o,
  output logic                   pad_oe_o,
  input  logic [XB_DW-1:0]       pad_i,
  output logic                   we_n_o,
  output logic                   cs_n_o
);
  localparam int unsigned UW = XB_AW - XB_DW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rs_q <= 2'b00;
    else          rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic e, ph_first, ph_last;
  xbus_phase_gen #(.HALF_CLKS(HALF_CLKS)) u_phase (
    .clk_i   (clk_i),
    .rst_n_i (srst_n),
    .e_o     (e),
    .first_o (ph_first),
    .last_o  (ph_last)
  );

  xbus_req_t req_in, launch_req;
  logic      launch;
  assign req_in = '{addr: req_addr_i, rd: req_rd_i, wdata: req_wdata_i};

  xbus_req_slot u_slot (
    .clk_i         (clk_i),
    .rst_n_i       (srst_n),
    .req_i         (req_i),
    .req_data_i    (req_in),
    .boundary_i    (ph_last),
    .launch_o      (launch),
    .launch_data_o (launch_req)
  );

  // cycle state
  logic             busy_q, busy_d;
  xbus_req_t        cyc_q, cyc_d;
  logic             done_q, done_d;
  logic [XB_DW-1:0] rdata_q, rdata_d;
  logic             cyc_en;

  assign cyc_en = ph_last;

  always_comb begin
    busy_d  = busy_q;
    cyc_d   = cyc_q;
    rdata_d = rdata_q;
    done_d  = ph_last && busy_q;
    if (ph_last) begin
      if (busy_q && cyc_q.rd) rdata_d = pad_i;
      busy_d = launch;
      if (launch) cyc_d = launch_req;
      else        cyc_d.rd = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      busy_q  <= 1'b0;
      cyc_q   <= '{addr: '0, rd: 1'b1, wdata: '0};
      rdata_q <= '0;
    end else if (cyc_en) begin
      busy_q  <= busy_d;
      cyc_q   <= cyc_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  // pin outputs
  assign e_o      = e;
  assign as_o     = busy_q && ph_first;
  assign rw_o     = cyc_q.rd;
  assign ah_o     = cyc_q.addr[XB_AW-1 -: UW];
  assign pad_o    = e ? cyc_q.wdata : cyc_q.addr[XB_DW-1:0];
  assign pad_oe_o = busy_q && (!e || !cyc_q.rd);
  assign we_n_o   = ~(e & ~cyc_q.rd);
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;

  xbus_cs_dec #(.DEC_W(DEC_W), .CS_BLOCK(CS_BLOCK)) u_cs (
    .top_bits_i (cyc_q.addr[XB_AW-1 -: DEC_W]),
    .active_i   (busy_q),
    .cs_n_o     (cs_n_o)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int unsigned UW = 8,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_n_i,
  input logic          e_o,
  input logic          as_o,
  input logic          rw_o,
  input logic [UW-1:0] ah_o,
  input logic          pad_oe_o,
  input logic          we_n_o,
  input logic          cs_n_o,
  input logic          done_o,
  input logic [DW-1:0] rdata_o
);
  // R2
  as_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    as_o |-> !e_o);
  // R2
  as_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    as_o |=> !as_o);
  // R6
  we_write_high_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !we_n_o |-> (e_o && !rw_o));
  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (e_o && $past(e_o)) |-> ($stable(ah_o) && $stable(rw_o)));
  // R5
  read_float_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (e_o && rw_o) |-> !pad_oe_o);
  // R8
  done_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> (!e_o && $past(e_o)));
  // R8
  rdata_write_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (done_o && !$past(rw_o)) |-> $stable(rdata_o));
  // R7
  cs_starts_with_as_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(cs_n_o) |-> as_o);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.UW(xbus_pkg::XB_AW - xbus_pkg::XB_DW), .DW(xbus_pkg::XB_DW)) u_chk (
  .clk_i    (clk_i),
  .rst_n_i  (rst_n_i),
  .e_o      (e_o),
  .as_o     (as_o),
  .rw_o     (rw_o),
  .ah_o     (ah_o),
  .pad_oe_o (pad_oe_o),
  .we_n_o   (we_n_o),
  .cs_n_o   (cs_n_o),
  .done_o   (done_o),
  .rdata_o  (rdata_o)
);

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] BLK = 3'd2;
  localparam logic [7:0] FLOAT_VAL = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [15:0] raddr;
  logic        rrd;
  logic [7:0]  rwd;
  logic        done_o, e_o, as_o, rw_o, pad_oe_o, we_n_o, cs_n_o;
  logic [7:0]  rdata_o, ah_o, pad_o, pad_i;

  int total = 0;
  int fails = 0;
  logic [7:0] sh [256];
  logic [7:0] mem [256];
  logic [7:0] lat_q;
  logic [7:0] exp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl i_xbus_ctrl (
    .clk_i(clk), .rst_n_i(rst_n), .req_i(req), .req_addr_i(raddr),
    .req_rd_i(rrd), .req_wdata_i(rwd), .done_o(done_o), .rdata_o(rdata_o),
    .e_o(e_o), .as_o(as_o), .rw_o(rw_o), .ah_o(ah_o), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .pad_i(pad_i), .we_n_o(we_n_o), .cs_n_o(cs_n_o)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 7 + 3) ^ 8'h3C);
  endfunction

  function automatic logic is_hit(input logic [15:0] a);
    return a[15:13] == BLK;
  endfunction

  // external RAM model with low-address latch
  always @(negedge clk) begin
    if (as_o) lat_q <= pad_o;
    if (!we_n_o && !cs_n_o) mem[lat_q] <= pad_o;
  end
  assign pad_i = cs_n_o ? FLOAT_VAL : mem[lat_q];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic drive_req(input logic en, input logic [15:0] a, input logic r, input logic [7:0] w);
    req = en; raddr = a; rrd = r; rwd = w;
  endtask

  // entered at the negedge of the strobe clock; returns at the done clock
  task automatic expect_cycle(input logic [15:0] a, input logic r, input logic [7:0] w,
                              input logic s1, input logic [15:0] a1, input logic r1, input logic [7:0] w1,
                              input logic s2, input logic [15:0] a2, input logic r2, input logic [7:0] w2);
    logic hit = is_hit(a);
    chk("R2 strobe in first clock", 16'(as_o), 16'd1);
    chk("R1 E low at start", 16'(e_o), 16'd0);
    chk("R4 low addr on pins", 16'(pad_o), 16'(a[7:0]));
    chk("R4 oe in E low", 16'(pad_oe_o), 16'd1);
    chk("R3 upper addr", 16'(ah_o), 16'(a[15:8]));
    chk("R3 rw line", 16'(rw_o), 16'(r));
    chk("R7 chip select", 16'(cs_n_o), 16'(!hit));
    chk("R6 we high in E low", 16'(we_n_o), 16'd1);
    @(negedge clk);
    drive_req(s1, a1, r1, w1);
    chk("R2 strobe one clock", 16'(as_o), 16'd0);
    chk("R1 E low second clock", 16'(e_o), 16'd0);
    chk("R4 low addr held", 16'(pad_o), 16'(a[7:0]));
    chk("R7 select held", 16'(cs_n_o), 16'(!hit));
    chk("R8 no early done", 16'(done_o), 16'd0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (k == 0) drive_req(s2, a2, r2, w2);
      else        drive_req(1'b0, 16'h0, 1'b1, 8'h0);
      chk("R1 E high", 16'(e_o), 16'd1);
      chk("R3 upper addr in E high", 16'(ah_o), 16'(a[15:8]));
      chk("R3 rw in E high", 16'(rw_o), 16'(r));
      chk("R7 select in E high", 16'(cs_n_o), 16'(!hit));
      if (r) begin
        chk("R5 oe released on read", 16'(pad_oe_o), 16'd0);
        chk("R6 we high on read", 16'(we_n_o), 16'd1);
      end else begin
        chk("R4 write data on pins", 16'(pad_o), 16'(w));
        chk("R4 oe on write", 16'(pad_oe_o), 16'd1);
        chk("R6 we low on write", 16'(we_n_o), 16'd0);
      end
    end
    @(negedge clk);
    chk("R8 done pulse", 16'(done_o), 16'd1);
    chk("R1 E fell", 16'(e_o), 16'd0);
    if (r) exp_rdata = hit ? sh[a[7:0]] : FLOAT_VAL;
    else if (hit) sh[a[7:0]] = w;
    chk(r ? "R5 read data" : "R8 rdata kept on write", 16'(rdata_o), 16'(exp_rdata));
  endtask

  task automatic issue(input logic [15:0] a, input logic r, input logic [7:0] w);
    int k = 0;
    @(negedge clk);
    drive_req(1'b1, a, r, w);
    @(negedge clk);
    drive_req(1'b0, 16'h0, 1'b1, 8'h0);
    while (!as_o && k < 3) begin
      @(negedge clk);
      k++;
    end
    chk("R9 start within one E period", 16'(as_o), 16'd1);
  endtask

  task automatic idle_check();
    logic [3:0] ep;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ep[k] = e_o;
      chk("R2 no strobe idle", 16'(as_o), 16'd0);
      chk("R7 no select idle", 16'(cs_n_o), 16'd1);
      chk("R6 no we idle", 16'(we_n_o), 16'd1);
      chk("R4 no oe idle", 16'(pad_oe_o), 16'd0);
      chk("R3 rw reads 1 idle", 16'(rw_o), 16'd1);
    end
    chk("R1 E pattern idle", 16'(ep), 16'b0110);
  endtask

  task automatic run(input logic [15:0] a, input logic r, input logic [7:0] w);
    issue(a, r, w);
    expect_cycle(a, r, w, 1'b0, 16'h0, 1'b1, 8'h0, 1'b0, 16'h0, 1'b1, 8'h0);
    idle_check();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic seen;
    void'($urandom(32'h5EED_0011));
    for (int i = 0; i < 256; i++) begin
      sh[i] = init_val(i);
      mem[i] = init_val(i);
    end
    exp_rdata = 8'h00;
    lat_q = 8'h00;
    rst_n = 1'b0;
    drive_req(1'b0, 16'h0, 1'b1, 8'h0);
    repeat (3) @(negedge clk);
    chk("R12 E reset", 16'(e_o), 16'd0);
    chk("R12 strobe reset", 16'(as_o), 16'd0);
    chk("R12 done reset", 16'(done_o), 16'd0);
    chk("R12 oe reset", 16'(pad_oe_o), 16'd0);
    chk("R12 we reset", 16'(we_n_o), 16'd1);
    chk("R12 cs reset", 16'(cs_n_o), 16'd1);
    chk("R12 rdata reset", 16'(rdata_o), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed
    run(16'h4012, 1'b0, 8'h5A);
    run(16'h4012, 1'b1, 8'h00);
    run(16'h2012, 1'b1, 8'h00);
    run(16'hE012, 1'b0, 8'hC3);
    run(16'h4012, 1'b1, 8'h00);
    run(16'h5FFF, 1'b0, 8'hFF);
    run(16'h5FFF, 1'b1, 8'h00);

    // random
    for (int n = 0; n < 40; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom % 2 == 0) a[15:13] = BLK;
      a[7:0] = 8'($urandom % 16);
      run(a, 1'($urandom), 8'($urandom));
    end

    // back-to-back with waiting slot (R10) and dropped request (R11)
    issue(16'h4020, 1'b0, 8'h11);
    expect_cycle(16'h4020, 1'b0, 8'h11,
                 1'b1, 16'h4020, 1'b1, 8'h00,
                 1'b1, 16'h4077, 1'b0, 8'hEE);
    chk("R10 queued strobe with done", 16'(as_o), 16'd1);
    chk("R10 queued upper addr", 16'(ah_o), 16'h40);
    expect_cycle(16'h4020, 1'b1, 8'h00, 1'b0, 16'h0, 1'b1, 8'h0, 1'b0, 16'h0, 1'b1, 8'h0);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (as_o) seen = 1'b1;
    end
    chk("R11 dropped request makes no cycle", 16'(seen), 16'd0);
    run(16'h4077, 1'b1, 8'h00);

    summary();
    $finish;
  end
endmodule